// File: doc/BRIEF.md
# Power-Down and Autocalibration Sequencer

This block sequences the power state of a set of converter-side subsystems and controls when their offset calibration runs. When the chip reset is released, it starts a calibration cycle on its own. It holds the converters not-ready for the fixed calibration interval, then marks the calibration data valid and lets the converters run. A hardware power-down pin throws away the stored calibration result, and a fresh cycle runs when the pin is released.

Software can put the subsystems to sleep through a single global power-down request. That request overrides every per-block enable. Calibration data survives software sleep, so on wake-up the converters are ready again in the next cycle. An optional calibrate-on-wake bit makes the block run a new calibration cycle on wake-up instead. The calibration engine is modelled as a timed interval counted on the reference clock.

Top module: `pwr_cal_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `blk_pwr_o`, `cal_start_o`, `cal_valid_o`, `busy_o` and `ready_o` are all 0.
- R2: On the first clock edge with `rst` and `hw_pdn_i` low after a hardware-off state, `cal_start_o` pulses high for exactly one cycle and `busy_o` rises at the same edge. No register programming is needed for this.
- R3: `busy_o` stays high for exactly `CAL_CYCLES` cycles. At the following edge `busy_o` falls and `cal_valid_o` rises.
- R4: A clock edge with `hw_pdn_i` high forces `cal_valid_o`, `busy_o`, `ready_o` and `blk_pwr_o` to 0 from the next cycle, whatever the other inputs are. A new calibration starts when the pin is released (R2).
- R5: With `sw_pdn_i` high in the run state, `ready_o` and all `blk_pwr_o` bits go to 0 at the next edge and `cal_valid_o` stays 1. When `sw_pdn_i` drops while `cal_on_wake_i` is 0, `ready_o` returns at the next edge and no calibration starts.
- R6: When `sw_pdn_i` drops while `cal_on_wake_i` is 1, a calibration cycle starts as in R2 and lasts as in R3. `cal_valid_o` stays 1 throughout.
- R7: A software power-down request raised during calibration has no effect until the calibration completes. `busy_o` runs its full `CAL_CYCLES`, and then the block goes directly to software power-down with `cal_valid_o` high.
- R8: Bit i of `blk_pwr_o` equals bit i of `blk_en_i`, sampled at the previous edge, whenever `busy_o` or `ready_o` is high. It is 0 otherwise.
- R9: `busy_o` and `ready_o` are never high together, and `cal_start_o` is only ever high together with `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the calibration time is counted on it |
| rst | input | 1 | Hardware reset, synchronous, active high; clears calibration data |
| hw_pdn_i | input | 1 | Hardware power-down pin, active high; clears calibration data |
| sw_pdn_i | input | 1 | Global software power-down request |
| cal_on_wake_i | input | 1 | Recalibrate on exit from software power-down |
| blk_en_i | input | NBLK | Per-block enable bits (clock generators, bit clocks, conversion clocks, clock output) |
| blk_pwr_o | output | NBLK | Gated per-block power enables |
| cal_start_o | output | 1 | One-cycle pulse at the start of each calibration cycle |
| cal_valid_o | output | 1 | Stored calibration data is valid |
| busy_o | output | 1 | Calibration in progress |
| ready_o | output | 1 | Converters usable (run state) |

## Verification
The gating function is driven through a vector table of different enable patterns: all ones, alternating bits, a single low bit and a single high bit. These are interleaved with software sleep and wake steps, which shows that the bit order is kept and that the global override clears every bit. The directed sequences reach calibration from three entry points: reset release, hardware pin release and wake with the recalibrate option set. These separate a calibration that clears validity from one that keeps it. Counting the busy interval from each entry point exposes off-by-one timer errors. A software request raised during a calibration is used to tell deferral apart from premature shutdown.

// File: rtl/pwr_cal_pkg.sv
package pwr_cal_pkg;
  typedef enum logic [1:0] {
    PS_HWOFF = 2'd0,
    PS_CAL   = 2'd1,
    PS_RUN   = 2'd2,
    PS_SWPDN = 2'd3
  } pstate_t;
endpackage

// File: rtl/cal_timer.sv
module cal_timer #(
  parameter int CAL_CYCLES = 98304
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int CW = $clog2(CAL_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CAL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= LOAD_VAL;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R3: a restart always reloads the full interval
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == LOAD_VAL);
  // R3: the count goes down by exactly one per cycle
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate #(
  parameter int NBLK = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            allow,
  input  logic [NBLK-1:0] en,
  output logic [NBLK-1:0] pwr
);
  for (genvar i = 0; i < NBLK; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) pwr[i] <= 1'b0;
      else     pwr[i] <= en[i] & allow;
    end
  end
endmodule

// File: rtl/pwr_cal_seq.sv
module pwr_cal_seq
  import pwr_cal_pkg::*;
#(
  parameter int NBLK       = 10,
  parameter int CAL_CYCLES = 98304
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_pdn_i,
  input  logic            sw_pdn_i,
  input  logic            cal_on_wake_i,
  input  logic [NBLK-1:0] blk_en_i,
  output logic [NBLK-1:0] blk_pwr_o,
  output logic            cal_start_o,
  output logic            cal_valid_o,
  output logic            busy_o,
  output logic            ready_o
);
  pstate_t state_q, state_nx;
  logic    tmr_load, tmr_zero, cal_done, pwr_allow;

  cal_timer #(.CAL_CYCLES(CAL_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .zero (tmr_zero)
  );

  assign cal_done = (state_q == PS_CAL) && tmr_zero;

  // next state; the hardware pin wins over everything else
  always_comb begin
    state_nx = state_q;
    tmr_load = 1'b0;
    if (hw_pdn_i) begin
      state_nx = PS_HWOFF;
    end else begin
      case (state_q)
        PS_HWOFF: begin
          state_nx = PS_CAL;
          tmr_load = 1'b1;
        end
        PS_CAL: begin
          if (cal_done) state_nx = sw_pdn_i ? PS_SWPDN : PS_RUN;
        end
        PS_RUN: begin
          if (sw_pdn_i) state_nx = PS_SWPDN;
        end
        PS_SWPDN: begin
          if (!sw_pdn_i) begin
            if (cal_on_wake_i) begin
              state_nx = PS_CAL;
              tmr_load = 1'b1;
            end else begin
              state_nx = PS_RUN;
            end
          end
        end
        default: state_nx = PS_HWOFF;
      endcase
    end
  end

  assign pwr_allow = (state_nx == PS_RUN) || (state_nx == PS_CAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_HWOFF;
      cal_start_o <= 1'b0;
      cal_valid_o <= 1'b0;
      busy_o      <= 1'b0;
      ready_o     <= 1'b0;
    end else begin
      state_q     <= state_nx;
      cal_start_o <= tmr_load;
      busy_o      <= (state_nx == PS_CAL);
      ready_o     <= (state_nx == PS_RUN);
      if (state_nx == PS_HWOFF) cal_valid_o <= 1'b0;
      else if (cal_done)        cal_valid_o <= 1'b1;
    end
  end

  pwr_gate #(.NBLK(NBLK)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .allow (pwr_allow),
    .en    (blk_en_i),
    .pwr   (blk_pwr_o)
  );

  // R2: the start pulse is one cycle wide
  a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |=> !cal_start_o);
  // R9: start only while calibrating
  a_r9_start_in_cal: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |-> busy_o);
  // R9: busy and ready are exclusive
  a_r9_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && ready_o));
  // R4: the hardware pin clears validity and power
  a_r4_hw_clear: assert property (@(posedge clk) disable iff (rst)
    hw_pdn_i |=> (!cal_valid_o && !busy_o && !ready_o && blk_pwr_o == '0));
  // R8: no block is powered while idle
  a_r8_idle_off: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !ready_o) |-> blk_pwr_o == '0);
  // R5: software sleep keeps the calibration data
  a_r5_sw_keep: assert property (@(posedge clk) disable iff (rst)
    (ready_o && sw_pdn_i && !hw_pdn_i) |=> cal_valid_o);
endmodule

// File: tb/pwr_cal_seq_tb.sv
module pwr_cal_seq_tb;
  localparam int NBLK = 10;
  localparam int CALN = 16;

  logic clk = 1'b0;
  logic rst, hw_pdn, sw_pdn, wake_cal;
  logic [NBLK-1:0] blk_en;
  logic [NBLK-1:0] blk_pwr;
  logic cal_start, cal_valid, busy, ready;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwr_cal_seq #(.NBLK(NBLK), .CAL_CYCLES(CALN)) u_dut (
    .clk(clk), .rst(rst), .hw_pdn_i(hw_pdn), .sw_pdn_i(sw_pdn),
    .cal_on_wake_i(wake_cal), .blk_en_i(blk_en), .blk_pwr_o(blk_pwr),
    .cal_start_o(cal_start), .cal_valid_o(cal_valid), .busy_o(busy),
    .ready_o(ready)
  );

  // {sw_pdn, blk_en, expected blk_pwr, expected ready}
  localparam logic [21:0] VEC [0:5] = '{
    {1'b0, 10'h3FF, 10'h3FF, 1'b1},
    {1'b0, 10'h155, 10'h155, 1'b1},
    {1'b1, 10'h3FF, 10'h000, 1'b0},
    {1'b0, 10'h2AA, 10'h2AA, 1'b1},
    {1'b0, 10'h3FE, 10'h3FE, 1'b1},
    {1'b1, 10'h001, 10'h000, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // packs {pwr, start, valid, busy, ready}
  function automatic logic [31:0] st();
    return {18'd0, blk_pwr, cal_start, cal_valid, busy, ready};
  endfunction

  initial begin
    #100000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1; hw_pdn = 0; sw_pdn = 0; wake_cal = 0; blk_en = 10'h3FF;
    step(3);
    chk("R1 reset outputs", st(), 32'd0);
    rst = 0;
    step(1);
    chk("R2 auto start", st(), {18'd0, 10'h3FF, 4'b1010});
    step(1);
    chk("R2 single pulse", {31'd0, cal_start}, 32'd0);
    step(CALN - 2);
    chk("R3 still busy", {30'd0, busy, cal_valid}, 32'h2);
    step(1);
    chk("R3 done valid ready", {29'd0, cal_valid, busy, ready}, 32'h5);

    // R8 / R5 gating table
    for (int i = 0; i < 6; i++) begin
      sw_pdn = VEC[i][21];
      blk_en = VEC[i][20:11];
      step(1);
      chk("R8 gate", {22'd0, blk_pwr}, {22'd0, VEC[i][10:1]});
      chk("R5 ready", {31'd0, ready}, {31'd0, VEC[i][0]});
      chk("R5 valid kept", {30'd0, cal_valid, cal_start}, 32'h2);
    end

    // R4 hardware pin during software sleep
    blk_en = 10'h3FF;
    hw_pdn = 1;
    step(2);
    chk("R4 hw clears", st(), 32'd0);
    sw_pdn = 0;
    step(1);
    chk("R4 still off", st(), 32'd0);
    hw_pdn = 0;
    step(1);
    chk("R4 recal start", st(), {18'd0, 10'h3FF, 4'b1010});

    // R7 software request during calibration
    sw_pdn = 1;
    step(CALN - 1);
    chk("R7 held off", st(), {18'd0, 10'h3FF, 4'b0010});
    step(1);
    chk("R7 to sleep", st(), {18'd0, 10'h000, 4'b0100});

    // R6 wake with recalibration
    wake_cal = 1; sw_pdn = 0;
    step(1);
    chk("R6 wake cal", st(), {18'd0, 10'h3FF, 4'b1110});
    step(CALN - 1);
    chk("R6 busy full", {30'd0, busy, ready}, 32'h2);
    step(1);
    chk("R6 ready", st(), {18'd0, 10'h3FF, 4'b0101});

    // R5 wake without recalibration is immediate
    wake_cal = 0; sw_pdn = 1;
    step(1);
    sw_pdn = 0;
    step(1);
    chk("R5 immediate ready", st(), {18'd0, 10'h3FF, 4'b0101});

    // R1 reset from run
    rst = 1;
    step(1);
    chk("R1 reset from run", st(), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule